// File: doc/BRIEF.md
# Configurable CRC Calculation Unit

This block is a register-mapped CRC engine. Software reaches it through a simple 32-bit bus made of a byte address, a write strobe, write data and read data. Every word written to the data register is folded into a running checksum, and a read of the same register returns the current checksum. The generator polynomial, its width (32, 16, 8 or 7 bits) and the seed value loaded on a restart are all programmable. An incoming word can be bit-mirrored per byte, per half-word or across the whole word before it is folded in. The returned checksum can be bit-mirrored over the active width. An 8-bit scratch register is available to software and has no role in the arithmetic.

A typical use has four steps. Software sets the polynomial, the width and the seed. It then writes the control register with the restart bit set, streams the message one word per write, and reads the data register for the result. Each data write is fully absorbed in one clock, so words may be written back to back.

Top module: `crc_engine`

## Requirements
- R1: After reset, the data register reads 0xFFFFFFFF, the seed register 0xFFFFFFFF, the polynomial register 0x04C11DB7, and the control and scratch registers 0.
- R2: A write at byte offset 0x00 folds all 32 written bits, most significant first, into the running checksum in one clock. Each bit XORs into the top bit of the checksum; the checksum shifts left, and when that XOR is 1 the polynomial is XORed in. Successive writes accumulate. With no data write and no pending restart, the checksum holds.
- R3: Control bits [4:3] select the width N (0: 32, 1: 16, 2: 8, 3: 7). Only the low N bits of the polynomial and of the checksum take part, and a data read returns 0 above bit N-1.
- R4: Control bits [6:5] select input mirroring before the fold (0: none, 1: within each byte, 2: within each half-word, 3: across the 32-bit word).
- R5: Control bit 7 set makes a data read return the low N bits of the checksum in mirrored order.
- R6: Writing control (offset 0x08) with bit 0 set requests a restart. In the following clock the checksum is loaded from the seed register, and a read issued in that clock still returns the old value. Bit 0 always reads as 0.
- R7: A data write in the clock directly after a restart request starts its fold from the seed value instead of the old checksum.
- R8: The scratch register at offset 0x04 stores written bits [7:0], reads back with 0 above bit 7, and a write to it leaves the checksum unchanged.
- R9: The seed register (offset 0x10) and the polynomial register (offset 0x14) store and return all 32 bits.
- R10: Read data is registered. It shows the register addressed in a clock from the following clock on. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous clock's address |

## Verification
On every cycle the assertions check four things: the checksum holds when nothing should move it, a restart loads exactly the seed that was present, a data read never shows bits above the active width, and the control restart bit and the scratch upper bits always read as zero. The arithmetic itself cannot be shown by a cycle property. That covers each width with its polynomial, each mirroring mode, output mirroring, accumulation over several words, and folding from the seed right after a restart. These are shown only by the bench's scenarios, whose expected values come from a separate bit-serial model and from hand-derived cases such as a single low-order one bit, which leaves exactly the polynomial.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;

  localparam int REG_DW = 32;

  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_FREE = 8'h04;
  localparam logic [7:0] OFF_CTL  = 8'h08;
  localparam logic [7:0] OFF_SEED = 8'h10;
  localparam logic [7:0] OFF_POLY = 8'h14;

  typedef enum logic [1:0] {
    PW_32 = 2'd0,
    PW_16 = 2'd1,
    PW_8  = 2'd2,
    PW_7  = 2'd3
  } poly_w_e;

  typedef enum logic [1:0] {
    IR_NONE = 2'd0,
    IR_BYTE = 2'd1,
    IR_HALF = 2'd2,
    IR_WORD = 2'd3
  } in_rev_e;

  // Stored control fields, laid out as bits [7:3] of the control register.
  typedef struct packed {
    logic    out_rev;
    in_rev_e in_rev;
    poly_w_e pw;
  } ctl_t;

  function automatic logic [5:0] width_bits(poly_w_e w);
    case (w)
      PW_32:   return 6'd32;
      PW_16:   return 6'd16;
      PW_8:    return 6'd8;
      default: return 6'd7;
    endcase
  endfunction

  function automatic logic [REG_DW-1:0] width_mask(poly_w_e w);
    case (w)
      PW_32:   return 32'hFFFF_FFFF;
      PW_16:   return 32'h0000_FFFF;
      PW_8:    return 32'h0000_00FF;
      default: return 32'h0000_007F;
    endcase
  endfunction

  function automatic logic [4:0] top_index(poly_w_e w);
    logic [5:0] n;
    n = width_bits(w) - 6'd1;
    return n[4:0];
  endfunction

endpackage

// File: rtl/crc_in_swap.sv
module crc_in_swap
  import crc_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  in_rev_e           mode,
  output logic [DATA_W-1:0] dout
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  logic [DATA_W-1:0] byte_rev;
  logic [DATA_W-1:0] half_rev;
  logic [DATA_W-1:0] word_rev;

  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign byte_rev[g] = din[(g / BYTE_W) * BYTE_W + (BYTE_W - 1) - (g % BYTE_W)];
    assign half_rev[g] = din[(g / HALF_W) * HALF_W + (HALF_W - 1) - (g % HALF_W)];
    assign word_rev[g] = din[DATA_W - 1 - g];
  end

  always_comb begin
    case (mode)
      IR_BYTE: dout = byte_rev;
      IR_HALF: dout = half_rev;
      IR_WORD: dout = word_rev;
      default: dout = din;
    endcase
  end

endmodule

// File: rtl/crc_fold_core.sv
module crc_fold_core
  import crc_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [REG_DW-1:0] crc_in,
  input  logic [DATA_W-1:0] data,
  input  logic [REG_DW-1:0] poly,
  input  poly_w_e           pw,
  output logic [REG_DW-1:0] crc_out
);

  logic [REG_DW-1:0] msk;
  logic [REG_DW-1:0] pm;
  logic [4:0]        tb;

  assign msk = width_mask(pw);
  assign pm  = poly & msk;
  assign tb  = top_index(pw);

  // Unrolled bit-serial fold, most significant data bit first.
  always_comb begin
    logic [REG_DW-1:0] c;
    logic fb;
    c = crc_in & msk;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = c[tb] ^ data[i];
      c  = (c << 1) & msk;
      if (fb) c = c ^ pm;
    end
    crc_out = c;
  end

endmodule

// File: rtl/crc_out_swap.sv
module crc_out_swap
  import crc_unit_pkg::*;
(
  input  logic [REG_DW-1:0] val,
  input  poly_w_e           pw,
  input  logic              en,
  output logic [REG_DW-1:0] dout
);

  logic [REG_DW-1:0] masked;
  logic [REG_DW-1:0] mirrored;
  logic [5:0]        sh;

  assign masked = val & width_mask(pw);
  assign sh     = 6'd32 - width_bits(pw);

  for (genvar g = 0; g < REG_DW; g++) begin : g_mir
    assign mirrored[g] = masked[REG_DW - 1 - g];
  end

  assign dout = en ? (mirrored >> sh) : masked;

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_unit_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter int              FREE_W    = 8,
  parameter logic [31:0]     SEED_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0]     POLY_RST  = 32'h04C1_1DB7,
  parameter logic [31:0]     CRC_RST   = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);

  localparam int CTL_LSB = 3;
  localparam int CTL_W   = $bits(ctl_t);
  localparam int CTL_PAD = REG_DW - CTL_W - CTL_LSB;

  logic [REG_DW-1:0] crc_q;
  logic [REG_DW-1:0] seed_q;
  logic [REG_DW-1:0] poly_q;
  logic [FREE_W-1:0] free_q;
  ctl_t              ctl_q;
  logic              rst_pend;

  logic sel_data, sel_free, sel_ctl, sel_seed, sel_poly;
  logic data_wr, ctl_wr;

  assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
  assign sel_free = (bus_addr == ADDR_W'(OFF_FREE));
  assign sel_ctl  = (bus_addr == ADDR_W'(OFF_CTL));
  assign sel_seed = (bus_addr == ADDR_W'(OFF_SEED));
  assign sel_poly = (bus_addr == ADDR_W'(OFF_POLY));
  assign data_wr  = bus_we && sel_data;
  assign ctl_wr   = bus_we && sel_ctl;

  logic [REG_DW-1:0] din_sw;
  logic [REG_DW-1:0] fold_base;
  logic [REG_DW-1:0] fold_out;
  logic [REG_DW-1:0] view;

  crc_in_swap #(.DATA_W(REG_DW)) u_in (
    .din  (bus_wdata),
    .mode (ctl_q.in_rev),
    .dout (din_sw)
  );

  assign fold_base = rst_pend ? seed_q : crc_q;

  crc_fold_core #(.DATA_W(REG_DW)) u_fold (
    .crc_in  (fold_base),
    .data    (din_sw),
    .poly    (poly_q),
    .pw      (ctl_q.pw),
    .crc_out (fold_out)
  );

  crc_out_swap u_out (
    .val  (crc_q),
    .pw   (ctl_q.pw),
    .en   (ctl_q.out_rev),
    .dout (view)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      seed_q   <= SEED_RST;
      poly_q   <= POLY_RST;
      free_q   <= '0;
      ctl_q    <= '0;
      rst_pend <= 1'b0;
    end else begin
      rst_pend <= ctl_wr && bus_wdata[0];
      if (ctl_wr)                 ctl_q  <= ctl_t'(bus_wdata[CTL_LSB +: CTL_W]);
      if (bus_we && sel_seed)     seed_q <= bus_wdata;
      if (bus_we && sel_poly)     poly_q <= bus_wdata;
      if (bus_we && sel_free)     free_q <= bus_wdata[FREE_W-1:0];
    end
  end

  // Running checksum
  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= CRC_RST;
    end else if (data_wr) begin
      crc_q <= fold_out;
    end else if (rst_pend) begin
      crc_q <= seed_q;
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (1'b1)
        sel_data: bus_rdata <= view;
        sel_free: bus_rdata <= {{(REG_DW - FREE_W){1'b0}}, free_q};
        sel_ctl:  bus_rdata <= {{CTL_PAD{1'b0}}, ctl_q, {CTL_LSB{1'b0}}};
        sel_seed: bus_rdata <= seed_q;
        sel_poly: bus_rdata <= poly_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // Checksum only moves on a data write or a pending restart.
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!data_wr && !rst_pend) |=> (crc_q == $past(crc_q)));

  // A restart without a data write loads the seed present in that clock.
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (rst_pend && !data_wr) |=> (crc_q == $past(seed_q)));

  // Restart request bit never reads back as set.
  p_ctl_bit0_r6: assert property (@(posedge clk) disable iff (rst)
    sel_ctl |=> (bus_rdata[0] == 1'b0));

  // Data reads are confined to the active width.
  p_data_upper_r3: assert property (@(posedge clk) disable iff (rst)
    sel_data |=> ((bus_rdata & ~$past(width_mask(ctl_q.pw))) == '0));

  // Scratch register reads nothing above its width.
  p_free_high_r8: assert property (@(posedge clk) disable iff (rst)
    sel_free |=> (bus_rdata[REG_DW-1:FREE_W] == '0));

endmodule

// File: tb/sim_crc_engine.sv
module sim_crc_engine;

  localparam int AW = 5;
  localparam logic [AW-1:0] A_DATA = 5'h00;
  localparam logic [AW-1:0] A_FREE = 5'h04;
  localparam logic [AW-1:0] A_CTL  = 5'h08;
  localparam logic [AW-1:0] A_SEED = 5'h10;
  localparam logic [AW-1:0] A_POLY = 5'h14;
  localparam logic [AW-1:0] A_HOLE = 5'h0C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;

  always #10 clk = ~clk;

  crc_engine u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    fails  = 0;
  logic  issue   = 1'b0;
  logic  issue_d = 1'b0;
  bit    done    = 1'b0;

  // Model state
  logic [31:0] m_crc  = 32'hFFFF_FFFF;
  logic [31:0] m_seed = 32'hFFFF_FFFF;
  logic [31:0] m_poly = 32'h04C1_1DB7;
  logic [7:0]  m_free = 8'h00;
  logic [7:0]  m_ctl  = 8'h00;
  bit          m_pend = 1'b0;

  function automatic int nbits();
    case (m_ctl[4:3])
      2'd0: return 32;
      2'd1: return 16;
      2'd2: return 8;
      default: return 7;
    endcase
  endfunction

  function automatic logic [31:0] nmask();
    int n = nbits();
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [31:0] mirror_in(logic [31:0] d);
    logic [31:0] t;
    logic [31:0] r;
    t = {<<{d}};
    case (m_ctl[6:5])
      2'd1: r = {<<8{t}};
      2'd2: r = {<<16{t}};
      2'd3: r = t;
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] ref_fold(logic [31:0] c0, logic [31:0] d);
    int n = nbits();
    logic [31:0] m = nmask();
    logic [31:0] c = c0 & m;
    logic [31:0] p = m_poly & m;
    for (int i = 31; i >= 0; i--) begin
      logic top;
      top = ((c >> (n - 1)) & 32'h1) != 0;
      c = (c << 1) & m;
      if (top != d[i]) c = c ^ p;
    end
    return c;
  endfunction

  function automatic logic [31:0] view();
    logic [31:0] v = m_crc & nmask();
    if (m_ctl[7]) begin
      logic [31:0] r;
      r = {<<{v}};
      v = r >> (32 - nbits());
    end
    return v;
  endfunction

  // Scoreboard monitor
  always @(posedge clk) issue_d <= issue;

  always @(negedge clk) begin
    if (issue_d) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] base;
    bit          pnow;
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d; issue = 1'b0;
    pnow   = m_pend;
    base   = m_pend ? m_seed : m_crc;
    m_pend = 1'b0;
    if (a == A_DATA) m_crc = ref_fold(base, mirror_in(d));
    else if (pnow)   m_crc = m_seed;
    case (a)
      A_FREE: m_free = d[7:0];
      A_CTL:  begin m_ctl = d[7:0] & 8'hF8; m_pend = d[0]; end
      A_SEED: m_seed = d;
      A_POLY: m_poly = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; we = 1'b0; issue = 1'b1;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    if (m_pend) begin m_crc = m_seed; m_pend = 1'b0; end
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0; issue = 1'b0;
    if (m_pend) begin m_crc = m_seed; m_pend = 1'b0; end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R10: reset state and unmapped offset
    rd(A_DATA, 32'hFFFF_FFFF, "R1 data reset");
    rd(A_SEED, 32'hFFFF_FFFF, "R1 seed reset");
    rd(A_POLY, 32'h04C1_1DB7, "R1 poly reset");
    rd(A_CTL,  32'h0,         "R1 ctl reset");
    rd(A_FREE, 32'h0,         "R1 free reset");
    rd(A_HOLE, 32'h0,         "R10 unmapped reads zero");

    // R2: fold and accumulate with default settings
    wr(A_DATA, 32'h1234_5678);
    rd(A_DATA, view(), "R2 single word");
    wr(A_DATA, 32'hDEAD_BEEF);
    wr(A_DATA, 32'h0BAD_F00D);
    rd(A_DATA, view(), "R2 accumulate");
    rd(A_DATA, view(), "R2 holds without writes");

    // R9: full-width seed and polynomial
    wr(A_SEED, 32'hA5A5_5A5A);
    wr(A_POLY, 32'h8000_0001);
    rd(A_SEED, 32'hA5A5_5A5A, "R9 seed readback");
    rd(A_POLY, 32'h8000_0001, "R9 poly readback");

    // R6: restart; read in the next clock sees the old value, then the seed
    wr(A_POLY, 32'h04C1_1DB7);
    wr(A_SEED, 32'h1357_9BDF);
    wr(A_CTL, 32'h0000_0001);
    rd(A_DATA, view(), "R6 read right after request shows old");
    rd(A_DATA, 32'h1357_9BDF, "R6 reload from seed");
    rd(A_CTL, 32'h0, "R6 restart bit reads zero");

    // R2 hand case: seed 0, single low one bit leaves the polynomial
    wr(A_SEED, 32'h0);
    wr(A_CTL, 32'h1);
    idle();
    wr(A_DATA, 32'h0000_0001);
    rd(A_DATA, 32'h04C1_1DB7, "R2 lone low bit gives poly");

    // R7: data write directly after restart request folds from seed
    wr(A_SEED, 32'hFFFF_FFFF);
    wr(A_CTL, 32'h1);
    wr(A_DATA, 32'hCAFE_F00D);
    rd(A_DATA, view(), "R7 fold starts from seed");

    // R3: widths 16, 8, 7
    wr(A_POLY, 32'h0000_1021);
    wr(A_CTL, 32'h0000_0009);
    idle();
    rd(A_DATA, 32'h0000_FFFF, "R3 width16 seed masked");
    wr(A_DATA, 32'h3132_3334);
    rd(A_DATA, view(), "R3 width16 fold");
    wr(A_POLY, 32'hFFFF_FF07);
    wr(A_SEED, 32'h0);
    wr(A_CTL, 32'h0000_0011);
    wr(A_DATA, 32'h0000_0001);
    rd(A_DATA, 32'h0000_0007, "R3 width8 lone bit gives low poly");
    wr(A_DATA, 32'hA1B2_C3D4);
    rd(A_DATA, view(), "R3 width8 fold");
    wr(A_POLY, 32'h0000_0009);
    wr(A_SEED, 32'hFFFF_FFFF);
    wr(A_CTL, 32'h0000_0019);
    idle();
    rd(A_DATA, 32'h0000_007F, "R3 width7 seed masked");
    wr(A_DATA, 32'h5566_7788);
    rd(A_DATA, view(), "R3 width7 fold");

    // R4: input mirroring modes at width 32
    wr(A_POLY, 32'h04C1_1DB7);
    for (int md = 1; md < 4; md++) begin
      wr(A_CTL, 32'(md << 5) | 32'h1);
      wr(A_DATA, 32'h1234_5678);
      rd(A_DATA, view(), $sformatf("R4 input mirror mode %0d", md));
    end
    wr(A_SEED, 32'h0);
    wr(A_CTL, 32'h0000_0061);
    wr(A_DATA, 32'h8000_0000);
    rd(A_DATA, 32'h04C1_1DB7, "R4 word mirror moves top bit to bottom");

    // R5: output mirroring at width 32 and 16
    wr(A_SEED, 32'hFFFF_FFFF);
    wr(A_CTL, 32'h0000_0081);
    wr(A_DATA, 32'h0F0F_1234);
    rd(A_DATA, view(), "R5 mirror out width32");
    wr(A_SEED, 32'h0000_0001);
    wr(A_POLY, 32'h0000_1021);
    wr(A_CTL, 32'h0000_0089);
    idle();
    rd(A_DATA, 32'h0000_8000, "R5 mirror out width16 only low bits");
    rd(A_CTL, 32'h0000_0088, "R5 control readback");

    // R8: scratch register and its lack of effect
    wr(A_DATA, 32'h0000_00FF);
    rd(A_DATA, view(), "R8 before scratch write");
    wr(A_FREE, 32'hFFFF_F1AB);
    rd(A_FREE, 32'h0000_00AB, "R8 scratch keeps 8 bits");
    rd(A_DATA, view(), "R8 scratch write leaves checksum");

    idle();
    idle();
    idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule